// File: doc/BRIEF.md
# DMA Address Translation Buffer

This block turns the 32-bit virtual addresses carried by incoming PCI DMA transactions into 41-bit system physical addresses. It keeps a small, fully associative set of recent translations. Behind it sits a page table in system memory that software owns. Pages are 8 KB, so the low 13 address bits pass through unchanged and the 19-bit virtual page number is looked up. With the default table of 8192 entries the DMA window is 64 MB.

A request is presented for one cycle and always gets exactly one registered answer in the next cycle: a translation, a retry or an error. A miss does not stall the requester. It answers retry, so the bus interface can retry the PCI transaction, and it starts a table-walk read of the entry at `tableBase + vpn*8`. The entry returned by memory is installed into a slot picked round-robin. The next attempt of the transaction then hits. Software can drop every cached translation with a single invalidate pulse.

Top module: `iotlb_xlate`

## Requirements
- R1: After reset every response output is low, `walkReq` is low, and no translation is cached, so the first request to any in-window page is answered with retry.
- R2: Each cycle with `reqValid` high produces, in the following cycle, `rspValid` high with exactly one of `rspHit`, `rspRetry`, `rspError`. On a hit `rspPaddr` is {cached physical page number, `reqVaddr[12:0]`} and `rspStreamable` is the cached streamable bit. With `reqValid` low, `rspValid` and all three kinds are low in the next cycle.
- R3: A request that misses while no walk is pending is answered with retry. From the next cycle `walkReq` is high, and `walkAddr` equals `tableBase + reqVaddr[31:13]*8`, held stable until the walk response.
- R4: While a walk is pending, every request is answered with retry, including one that would hit or lies outside the window, and no second walk starts.
- R5: A walk response (`walkRespValid` high for one cycle) ends the walk, so `walkReq` is low in the next cycle. If bit 30 of `walkRespData` (valid) is set, the entry is installed for the walked page. The entry takes bit 29 as streamable, bit 28 as writable and bits 27:0 as the physical page number.
- R6: A walk response with bit 30 clear installs nothing; a later request to that page misses and walks again.
- R7: A write request (`reqWrite` high) that hits a page whose writable bit is clear is answered with `rspError` and no translation; a read of that page still hits.
- R8: A request, with no walk pending, whose page number is at or above 2^13 (address at or above 64 MB) is answered with `rspError` and starts no walk.
- R9: Fills use slots in round-robin order, so after 17 distinct pages are filled, the first of them has been evicted and misses while the others still hit.
- R10: `invalidateAll` clears every cached translation at the clock edge. A request in that same cycle is looked up against the old contents. A walk response arriving in that same cycle is discarded.
- R11: `rspPaddr` and `rspStreamable` are zero in every cycle where `rspHit` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tableBase | input | 41 | Physical base address of the page table |
| reqValid | input | 1 | Translation request strobe |
| reqVaddr | input | 32 | DMA virtual address |
| reqWrite | input | 1 | Request is a write |
| invalidateAll | input | 1 | Drop all cached translations |
| walkReq | output | 1 | Table-walk read pending |
| walkAddr | output | 41 | Address of the page-table entry to read |
| walkRespValid | input | 1 | Table-walk data returned |
| walkRespData | input | 31 | Entry: valid, streamable, writable, physical page number |
| rspValid | output | 1 | Response present |
| rspHit | output | 1 | Translation delivered |
| rspRetry | output | 1 | Transaction must be retried |
| rspError | output | 1 | Write-protect or out-of-window error |
| rspPaddr | output | 41 | Physical address on a hit, else zero |
| rspStreamable | output | 1 | Streamable attribute on a hit, else zero |

## Verification
The bench targets the cycles where two events coincide. An invalidate that lands with a walk response must discard the fill; a design that lets the fill through would hit on a page software just dropped. An invalidate that lands with a lookup must still answer from the old contents. A cached page requested during a walk must be retried; a design that answered it would let a second transaction slip past the pending one. The bench also fills 17 pages to catch a victim pointer that wraps or advances wrongly, and it checks that a walk returning an invalid entry leaves the buffer untouched. Writes to protected pages and addresses past the window must fail at once, without a walk.

// File: rtl/iotlb_pkg.sv
package iotlb_pkg;

  // Strobes from control to datapath for one clock.
  typedef struct packed {
    logic startWalk;   // latch the missing page number
    logic capture;     // register the translated address
    logic fill;        // write the walked entry into the victim slot
    logic invalidate;  // clear every valid bit
  } dpStrobes_t;

  typedef enum logic [1:0] {
    RSP_NONE,
    RSP_HIT,
    RSP_RETRY,
    RSP_ERROR
  } rspKind_t;

endpackage

// File: rtl/iotlb_dp.sv
module iotlb_dp
  import iotlb_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 41,
  parameter int PAGE_BITS = 13,
  parameter int ENTRIES   = 16,
  parameter int TSB_LOG2  = 13
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  dpStrobes_t                     st,
  input  logic [VA_W-1:0]                reqVaddr,
  input  logic [PA_W-1:0]                tableBase,
  input  logic [PA_W-PAGE_BITS+1:0]      walkEntry,   // stream, writable, ppn
  output logic                           hit,
  output logic                           hitWritable,
  output logic                           outOfWindow,
  output logic [PA_W-1:0]                walkAddr,
  output logic [PA_W-1:0]                rspPaddr,
  output logic                           rspStreamable
);

  localparam int VPN_W = VA_W - PAGE_BITS;
  localparam int PPN_W = PA_W - PAGE_BITS;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [VPN_W-1:0] reqVpn;
  logic [VPN_W-1:0] walkVpn;
  logic [IDX_W-1:0] victim;

  logic [ENTRIES-1:0] entValid;
  logic [ENTRIES-1:0] entStream;
  logic [ENTRIES-1:0] entWrite;
  logic [VPN_W-1:0]   entVpn [ENTRIES];
  logic [PPN_W-1:0]   entPpn [ENTRIES];

  logic [ENTRIES-1:0] matchVec;
  logic [PPN_W-1:0]   hitPpn;
  logic               hitStream;

  assign reqVpn = reqVaddr[VA_W-1:PAGE_BITS];

  // Table window check: page numbers beyond the table are errors.
  generate
    if (TSB_LOG2 < VPN_W) begin : g_window
      assign outOfWindow = |reqVpn[VPN_W-1:TSB_LOG2];
    end else begin : g_nowindow
      assign outOfWindow = 1'b0;
    end
  endgenerate

  // Entry address: base plus eight bytes per page number.
  assign walkAddr = tableBase + PA_W'({walkVpn, 3'b000});

  // Parallel compare across all slots.
  generate
    for (genvar i = 0; i < ENTRIES; i++) begin : g_match
      assign matchVec[i] = entValid[i] && (entVpn[i] == reqVpn);
    end
  endgenerate

  always_comb begin
    hitPpn      = '0;
    hitStream   = 1'b0;
    hitWritable = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (matchVec[i]) begin
        hitPpn      = hitPpn | entPpn[i];
        hitStream   = hitStream | entStream[i];
        hitWritable = hitWritable | entWrite[i];
      end
    end
  end

  assign hit = |matchVec;

  // Valid bits and the round-robin victim pointer.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entValid <= '0;
      victim   <= '0;
      walkVpn  <= '0;
    end else begin
      if (st.startWalk) walkVpn <= reqVpn;
      if (st.invalidate) begin
        entValid <= '0;
      end else if (st.fill) begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (victim == IDX_W'(i)) entValid[i] <= 1'b1;
        end
      end
      if (st.fill) begin
        victim <= (victim == IDX_W'(ENTRIES - 1)) ? '0 : victim + 1'b1;
      end
    end
  end

  // Entry payload needs no reset: it is qualified by the valid bit.
  always_ff @(posedge clk) begin
    if (st.fill) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (victim == IDX_W'(i)) begin
          entVpn[i]    <= walkVpn;
          entStream[i] <= walkEntry[PPN_W+1];
          entWrite[i]  <= walkEntry[PPN_W];
          entPpn[i]    <= walkEntry[PPN_W-1:0];
        end
      end
    end
  end

  // Registered translation, forced to zero when no hit is reported.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspPaddr      <= '0;
      rspStreamable <= 1'b0;
    end else begin
      rspPaddr      <= st.capture ? {hitPpn, reqVaddr[PAGE_BITS-1:0]} : '0;
      rspStreamable <= st.capture ? hitStream : 1'b0;
    end
  end

endmodule

// File: rtl/iotlb_ctrl.sv
module iotlb_ctrl
  import iotlb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic       invalidateAll,
  input  logic       hit,
  input  logic       hitWritable,
  input  logic       outOfWindow,
  input  logic       walkRespValid,
  input  logic       walkEntryValid,
  output dpStrobes_t st,
  output logic       walkReq,
  output logic       rspValid,
  output logic       rspHit,
  output logic       rspRetry,
  output logic       rspError
);

  logic     busy;
  rspKind_t kind;

  always_comb begin
    kind         = RSP_NONE;
    st           = '0;
    if (reqValid) begin
      if (busy) begin
        kind = RSP_RETRY;
      end else if (outOfWindow) begin
        kind = RSP_ERROR;
      end else if (hit) begin
        if (reqWrite && !hitWritable) begin
          kind = RSP_ERROR;
        end else begin
          kind       = RSP_HIT;
          st.capture = 1'b1;
        end
      end else begin
        kind         = RSP_RETRY;
        st.startWalk = 1'b1;
      end
    end
    st.invalidate = invalidateAll;
    st.fill       = busy && walkRespValid && walkEntryValid && !invalidateAll;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
      rspRetry <= 1'b0;
      rspError <= 1'b0;
    end else begin
      if (busy) busy <= !walkRespValid;
      else      busy <= st.startWalk;
      rspValid <= (kind != RSP_NONE);
      rspHit   <= (kind == RSP_HIT);
      rspRetry <= (kind == RSP_RETRY);
      rspError <= (kind == RSP_ERROR);
    end
  end

  assign walkReq = busy;

endmodule

// File: rtl/iotlb_xlate.sv
module iotlb_xlate
  import iotlb_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 41,
  parameter int PAGE_BITS = 13,
  parameter int ENTRIES   = 16,
  parameter int TSB_LOG2  = 13,
  localparam int ENT_W    = PA_W - PAGE_BITS + 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PA_W-1:0]  tableBase,
  input  logic             reqValid,
  input  logic [VA_W-1:0]  reqVaddr,
  input  logic             reqWrite,
  input  logic             invalidateAll,
  output logic             walkReq,
  output logic [PA_W-1:0]  walkAddr,
  input  logic             walkRespValid,
  input  logic [ENT_W-1:0] walkRespData,
  output logic             rspValid,
  output logic             rspHit,
  output logic             rspRetry,
  output logic             rspError,
  output logic [PA_W-1:0]  rspPaddr,
  output logic             rspStreamable
);

  dpStrobes_t st;
  logic hit;
  logic hitWritable;
  logic outOfWindow;

  iotlb_ctrl u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .reqValid       (reqValid),
    .reqWrite       (reqWrite),
    .invalidateAll  (invalidateAll),
    .hit            (hit),
    .hitWritable    (hitWritable),
    .outOfWindow    (outOfWindow),
    .walkRespValid  (walkRespValid),
    .walkEntryValid (walkRespData[ENT_W-1]),
    .st             (st),
    .walkReq        (walkReq),
    .rspValid       (rspValid),
    .rspHit         (rspHit),
    .rspRetry       (rspRetry),
    .rspError       (rspError)
  );

  iotlb_dp #(
    .VA_W      (VA_W),
    .PA_W      (PA_W),
    .PAGE_BITS (PAGE_BITS),
    .ENTRIES   (ENTRIES),
    .TSB_LOG2  (TSB_LOG2)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .st            (st),
    .reqVaddr      (reqVaddr),
    .tableBase     (tableBase),
    .walkEntry     (walkRespData[ENT_W-2:0]),
    .hit           (hit),
    .hitWritable   (hitWritable),
    .outOfWindow   (outOfWindow),
    .walkAddr      (walkAddr),
    .rspPaddr      (rspPaddr),
    .rspStreamable (rspStreamable)
  );

endmodule

// File: rtl/iotlb_xlate_chk.sv
module iotlb_xlate_chk #(
  parameter int VA_W      = 32,
  parameter int PA_W      = 41,
  parameter int PAGE_BITS = 13,
  parameter int TSB_LOG2  = 13
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic [VA_W-1:0] reqVaddr,
  input logic            walkReq,
  input logic [PA_W-1:0] walkAddr,
  input logic            walkRespValid,
  input logic            rspValid,
  input logic            rspHit,
  input logic            rspRetry,
  input logic            rspError,
  input logic [PA_W-1:0] rspPaddr,
  input logic            rspStreamable
);

  localparam logic [63:0] WINDOW_LIMIT = 64'(1) << (PAGE_BITS + TSB_LOG2);

  logic beyondWindow;
  assign beyondWindow = {32'b0, reqVaddr} >= WINDOW_LIMIT;

  a_r2_answer_follows: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  a_r2_single_kind: assert property (@(posedge clk) disable iff (!rstN)
    $countones({rspHit, rspRetry, rspError}) == (rspValid ? 1 : 0));

  a_r3_walk_held: assert property (@(posedge clk) disable iff (!rstN)
    (walkReq && !walkRespValid) |=> (walkReq && $stable(walkAddr)));

  a_r4_retry_during_walk: assert property (@(posedge clk) disable iff (!rstN)
    (walkReq && reqValid) |=> rspRetry);

  a_r5_walk_ends: assert property (@(posedge clk) disable iff (!rstN)
    (walkReq && walkRespValid) |=> !walkReq);

  a_r8_window_error: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !walkReq && beyondWindow) |=> (rspError && !walkReq));

  a_r11_quiet_paddr: assert property (@(posedge clk) disable iff (!rstN)
    !rspHit |-> (rspPaddr == '0 && !rspStreamable));

endmodule

bind iotlb_xlate iotlb_xlate_chk #(
  .VA_W      (VA_W),
  .PA_W      (PA_W),
  .PAGE_BITS (PAGE_BITS),
  .TSB_LOG2  (TSB_LOG2)
) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .reqValid      (reqValid),
  .reqVaddr      (reqVaddr),
  .walkReq       (walkReq),
  .walkAddr      (walkAddr),
  .walkRespValid (walkRespValid),
  .rspValid      (rspValid),
  .rspHit        (rspHit),
  .rspRetry      (rspRetry),
  .rspError      (rspError),
  .rspPaddr      (rspPaddr),
  .rspStreamable (rspStreamable)
);

// File: tb/iotlb_xlate_bench.sv
`timescale 1ns/1ps
module iotlb_xlate_bench;

  localparam logic [40:0] BASE = 41'h0AB_CDE0_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [40:0] tableBase = BASE;
  logic        reqValid = 1'b0;
  logic [31:0] reqVaddr = '0;
  logic        reqWrite = 1'b0;
  logic        invalidateAll = 1'b0;
  logic        walkReq;
  logic [40:0] walkAddr;
  logic        walkRespValid;
  logic [30:0] walkRespData;
  logic        rspValid, rspHit, rspRetry, rspError, rspStreamable;
  logic [40:0] rspPaddr;

  int checks = 0;
  int fails = 0;
  string phase = "R1";

  always #4 clk = ~clk;

  iotlb_xlate u_iotlb_xlate (
    .clk(clk), .rstN(rstN), .tableBase(tableBase), .reqValid(reqValid),
    .reqVaddr(reqVaddr), .reqWrite(reqWrite), .invalidateAll(invalidateAll),
    .walkReq(walkReq), .walkAddr(walkAddr), .walkRespValid(walkRespValid),
    .walkRespData(walkRespData), .rspValid(rspValid), .rspHit(rspHit),
    .rspRetry(rspRetry), .rspError(rspError), .rspPaddr(rspPaddr),
    .rspStreamable(rspStreamable)
  );

  // Page table contents: valid unless low nibble is F, streamable if odd,
  // writable unless bit 1 is set, page number = vpn*3 + 0x100.
  function automatic logic [30:0] tableEntry(logic [18:0] vpn);
    logic [27:0] ppn;
    ppn = 28'(vpn) * 28'd3 + 28'h100;
    return {vpn[3:0] != 4'hF, vpn[0], !vpn[1], ppn};
  endfunction

  // Memory responder: three cycles of latency per walk.
  int lat = 0;
  always @(posedge clk) begin
    if (!rstN) begin
      walkRespValid <= 1'b0;
      walkRespData  <= '0;
      lat = 0;
    end else if (walkReq && !walkRespValid) begin
      if (lat == 2) begin
        walkRespValid <= 1'b1;
        walkRespData  <= tableEntry(19'((walkAddr - BASE) >> 3));
        lat = 0;
      end else begin
        lat++;
      end
    end else begin
      walkRespValid <= 1'b0;
      lat = 0;
    end
  end

  // Behavioural reference model.
  logic        mValid [16];
  logic [18:0] mVpn [16];
  logic [27:0] mPpn [16];
  logic        mStr [16];
  logic        mWr [16];
  int          mPtr;
  logic        mBusy;
  logic [18:0] mWalkVpn;
  logic        eValid, eHit, eRetry, eErr, eStr;
  logic [40:0] ePaddr;

  always @(posedge clk) begin
    int hitIdx;
    logic [18:0] vpn;
    logic startW;
    if (!rstN) begin
      foreach (mValid[i]) mValid[i] = 1'b0;
      mPtr = 0; mBusy = 1'b0; mWalkVpn = '0;
      eValid = 0; eHit = 0; eRetry = 0; eErr = 0; eStr = 0; ePaddr = '0;
    end else begin
      vpn = reqVaddr[31:13];
      hitIdx = -1;
      for (int i = 0; i < 16; i++) if (mValid[i] && mVpn[i] == vpn) hitIdx = i;
      eValid = reqValid; eHit = 0; eRetry = 0; eErr = 0; eStr = 0; ePaddr = '0;
      startW = 1'b0;
      if (reqValid) begin
        if (mBusy) eRetry = 1;
        else if (vpn >= 19'd8192) eErr = 1;
        else if (hitIdx >= 0) begin
          if (reqWrite && !mWr[hitIdx]) eErr = 1;
          else begin
            eHit = 1; ePaddr = {mPpn[hitIdx], reqVaddr[12:0]}; eStr = mStr[hitIdx];
          end
        end else begin
          eRetry = 1; startW = 1'b1;
        end
      end
      if (mBusy && walkRespValid && walkRespData[30] && !invalidateAll) begin
        mValid[mPtr] = 1'b1; mVpn[mPtr] = mWalkVpn; mPpn[mPtr] = walkRespData[27:0];
        mStr[mPtr] = walkRespData[29]; mWr[mPtr] = walkRespData[28];
        mPtr = (mPtr + 1) % 16;
      end
      if (invalidateAll) foreach (mValid[i]) mValid[i] = 1'b0;
      if (mBusy) begin
        if (walkRespValid) mBusy = 1'b0;
      end else if (startW) begin
        mBusy = 1'b1; mWalkVpn = vpn;
      end
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s (%s): actual %h expected %h", tag, phase, act, exp);
    end
  endtask

  // Advance one clock and compare every output with the model.
  task automatic tick();
    @(posedge clk);
    #2;
    chk("R2 rspValid", 64'(rspValid), 64'(eValid));
    chk("R2 rspHit", 64'(rspHit), 64'(eHit));
    chk("R4 rspRetry", 64'(rspRetry), 64'(eRetry));
    chk("R7 rspError", 64'(rspError), 64'(eErr));
    chk("R11 rspPaddr", 64'(rspPaddr), 64'(ePaddr));
    chk("R11 rspStreamable", 64'(rspStreamable), 64'(eStr));
    chk("R3 walkReq", 64'(walkReq), 64'(mBusy));
    if (mBusy) chk("R3 walkAddr", 64'(walkAddr), 64'(BASE + 41'({mWalkVpn, 3'b000})));
  endtask

  task automatic access(logic [18:0] vpn, logic [12:0] off, logic wr);
    reqValid = 1'b1; reqVaddr = {vpn, off}; reqWrite = wr;
    tick();
    reqValid = 1'b0; reqWrite = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic fillPage(logic [18:0] vpn);
    for (int k = 0; k < 4; k++) begin
      access(vpn, 13'h0, 1'b0);
      if (rspHit) break;
      idle(6);
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    // R1: quiet outputs after reset, first access misses.
    phase = "R1";
    chk("R1 reset outputs", 64'({rspValid, rspHit, rspRetry, rspError, walkReq}), 64'd0);
    access(19'd1, 13'h123, 1'b0);
    chk("R1 first access retries", 64'(rspRetry), 64'd1);
    // R3: walk address for page 1.
    phase = "R3";
    tick();
    chk("R3 walk address", 64'(walkAddr), 64'(BASE + 41'd8));
    idle(5);
    // R5/R2: page now cached.
    phase = "R5";
    access(19'd1, 13'h0AB, 1'b0);
    chk("R5 filled page hits", 64'(rspHit), 64'd1);
    chk("R2 paddr composition", 64'(rspPaddr), 64'({28'h103, 13'h0AB}));
    chk("R5 streamable taken", 64'(rspStreamable), 64'd1);
    // R4: cached page is retried while page 2 walks.
    phase = "R4";
    access(19'd2, 13'h0, 1'b0);
    access(19'd1, 13'h0, 1'b0);
    chk("R4 hit retried during walk", 64'(rspRetry), 64'd1);
    access(19'd9000, 13'h0, 1'b0);
    chk("R4 out-of-window retried during walk", 64'(rspRetry), 64'd1);
    idle(6);
    // R7: page 2 is read-only.
    phase = "R7";
    access(19'd2, 13'h10, 1'b1);
    chk("R7 write to read-only errors", 64'({rspError, rspHit}), 64'b10);
    access(19'd2, 13'h10, 1'b0);
    chk("R7 read of read-only hits", 64'(rspHit), 64'd1);
    access(19'd1, 13'h10, 1'b1);
    chk("R7 write to writable hits", 64'(rspHit), 64'd1);
    // R6: page 15 has an invalid table entry.
    phase = "R6";
    access(19'd15, 13'h0, 1'b0);
    idle(6);
    access(19'd15, 13'h0, 1'b0);
    chk("R6 invalid entry not installed", 64'(rspRetry), 64'd1);
    tick();
    chk("R6 walks again", 64'(walkReq), 64'd1);
    idle(6);
    // R8: beyond the 64 MB window.
    phase = "R8";
    access(19'd8192, 13'h0, 1'b0);
    chk("R8 window error", 64'(rspError), 64'd1);
    tick();
    chk("R8 no walk", 64'(walkReq), 64'd0);
    access(19'd8191, 13'h0, 1'b0);
    chk("R8 last page inside window walks", 64'(rspRetry), 64'd1);
    idle(6);
    // R10: lookup in the invalidate cycle sees old contents.
    phase = "R10";
    reqValid = 1'b1; reqVaddr = {19'd1, 13'h0}; invalidateAll = 1'b1;
    tick();
    reqValid = 1'b0; invalidateAll = 1'b0;
    chk("R10 same-cycle lookup hits", 64'(rspHit), 64'd1);
    access(19'd1, 13'h0, 1'b0);
    chk("R10 cleared after invalidate", 64'(rspRetry), 64'd1);
    idle(6);
    // R10: fill coinciding with invalidate is discarded.
    access(19'd100, 13'h0, 1'b0);
    for (int k = 0; k < 10; k++) begin
      if (walkRespValid) break;
      tick();
    end
    invalidateAll = 1'b1;
    tick();
    invalidateAll = 1'b0;
    idle(2);
    access(19'd100, 13'h0, 1'b0);
    chk("R10 fill dropped by invalidate", 64'(rspRetry), 64'd1);
    idle(6);
    // R9: 17 fills evict the first one.
    phase = "R9";
    invalidateAll = 1'b1; tick(); invalidateAll = 1'b0;
    for (int k = 0; k < 17; k++) fillPage(19'(32 + 2 * k));
    access(19'd34, 13'h0, 1'b0);
    chk("R9 second fill still cached", 64'(rspHit), 64'd1);
    access(19'd64, 13'h0, 1'b0);
    chk("R9 latest fill cached", 64'(rspHit), 64'd1);
    access(19'd32, 13'h0, 1'b0);
    chk("R9 oldest fill evicted", 64'(rspRetry), 64'd1);
    idle(6);
    // Mixed pattern under the model.
    phase = "R2";
    for (int k = 0; k < 40; k++) begin
      access(19'(k % 7 + 40), 13'(k * 37), 1'(k % 3 == 0));
      if (k % 4 == 0) tick();
    end
    idle(8);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule